// File: doc/BRIEF.md
# Dual-Edge Sampling Register with Forced-Output Test Modes

This block is a register that takes a sample of its data input on every rising clock edge and on every falling clock edge. Each clock period therefore delivers two data values, and the clock can run at half the data rate. Internally there are two storage halves. One captures on the rising edge and drives the output for the whole high phase of the clock. The other captures on the falling edge and drives the output for the whole low phase. A clock-steered selector always forwards the half that is currently holding, so the output changes only at clock edges. It never follows the input while the input moves.

Each half has its own two-bit test control. With the normal code, the half shows what it stored. With a test code, the half presents a constant 0 or a constant 1 for its phase, so a tester can drive either level through the output path on either clock phase. Forcing acts only on what a half presents at the output. Capture goes on underneath, so the output shows the latest sample again as soon as the control returns to normal. An active-low asynchronous reset clears both halves.

Top module: `twin_edge_reg`

## Requirements
- R1: While `clk` is high and `highPhaseCtl` is 2'b01, `q` equals the value `dIn` had just before the most recent rising edge of `clk`.
- R2: While `clk` is low and `lowPhaseCtl` is 2'b01, `q` equals the value `dIn` had just before the most recent falling edge of `clk`.
- R3: A change of `dIn` between two clock edges has no effect on `q` until the next edge.
- R4: While `clk` is low, `lowPhaseCtl` selects a forced output: 2'b00 makes every bit of `q` 0, and 2'b10 or 2'b11 makes every bit of `q` 1.
- R5: While `clk` is high, `highPhaseCtl` selects a forced output using the same codes as R4: 2'b00 gives all zeros, and 2'b10 or 2'b11 gives all ones.
- R6: The control of one phase has no effect on `q` during the other phase.
- R7: Capture continues while a half is forced. When its control returns to 2'b01 in the middle of a phase, `q` at once shows the sample from that half's latest edge.
- R8: While `rstN` is 0, both stored samples are cleared at once, so with both controls at 2'b01 `q` reads all zeros on either clock phase.
- R9: Every bit of `q` follows its own bit of `dIn`, across the full `DATA_W` width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges capture data |
| rstN | input | 1 | Asynchronous active-low clear of both stored samples |
| dIn | input | DATA_W | Data to be sampled |
| lowPhaseCtl | input | 2 | Mode of the falling-edge half, which is shown while `clk` is low |
| highPhaseCtl | input | 2 | Mode of the rising-edge half, which is shown while `clk` is high |
| q | output | DATA_W | Registered output |

## Verification
The hardest case to reach from the ports is R7: a half keeps capturing while its output is forced, and that stored sample can only be seen after the control goes back to normal partway through a phase. The stimulus sweeps all sixteen pairs of control codes for a few half-periods each, so that each forced stretch is followed by a switch back to 2'b01 in the middle of a phase. A second stretch forces both halves low for several edges and then releases them. Data changes between edges on every half-period, and the output is sampled after each change, which exercises R3 and compares against edge samples tracked in the bench.

// File: rtl/twin_edge_pkg.sv
package twin_edge_pkg;

  // Two-bit phase control codes
  localparam logic [1:0] CTL_PASS  = 2'b01;
  localparam logic [1:0] CTL_ZERO  = 2'b00;

  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic lowForce;   // falling-edge half presents a constant
    logic lowLevel;   // constant for the falling-edge half
    logic highForce;  // rising-edge half presents a constant
    logic highLevel;  // constant for the rising-edge half
  } strobeT;

endpackage

// File: rtl/twin_edge_ctrl.sv
module twin_edge_ctrl
  import twin_edge_pkg::*;
(
  input  logic [1:0] lowPhaseCtl,
  input  logic [1:0] highPhaseCtl,
  output strobeT     strobes
);

  // Bit 1 set forces ones; code 00 forces zeros; only 01 passes the sample.
  function automatic logic isForced(input logic [1:0] ctl);
    return ctl[1] | ~ctl[0];
  endfunction

  always_comb begin
    strobes.lowForce  = isForced(lowPhaseCtl);
    strobes.lowLevel  = lowPhaseCtl[1];
    strobes.highForce = isForced(highPhaseCtl);
    strobes.highLevel = highPhaseCtl[1];
  end

endmodule

// File: rtl/twin_edge_cell.sv
module twin_edge_cell
  import twin_edge_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   dBit,
  input  strobeT strobes,
  output logic   qBit
);

  logic riseHold;  // sampled on the rising edge, shown while clk is high
  logic fallHold;  // sampled on the falling edge, shown while clk is low
  logic highOut;
  logic lowOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseHold <= 1'b0;
    else       riseHold <= dBit;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallHold <= 1'b0;
    else       fallHold <= dBit;
  end

  always_comb begin
    highOut = strobes.highForce ? strobes.highLevel : riseHold;
    lowOut  = strobes.lowForce  ? strobes.lowLevel  : fallHold;
    // forward whichever half is holding in this phase
    qBit    = clk ? highOut : lowOut;
  end

endmodule

// File: rtl/twin_edge_path.sv
module twin_edge_path
  import twin_edge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  strobeT            strobes,
  output logic [DATA_W-1:0] q
);

  for (genvar bitIdx = 0; bitIdx < DATA_W; bitIdx++) begin : gBit
    twin_edge_cell uCell (
      .clk    (clk),
      .rstN   (rstN),
      .dBit   (dIn[bitIdx]),
      .strobes(strobes),
      .qBit   (q[bitIdx])
    );
  end

endmodule

// File: rtl/twin_edge_reg.sv
module twin_edge_reg
  import twin_edge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  logic [1:0]        lowPhaseCtl,
  input  logic [1:0]        highPhaseCtl,
  output logic [DATA_W-1:0] q
);

  strobeT strobes;

  twin_edge_ctrl uCtrl (
    .lowPhaseCtl (lowPhaseCtl),
    .highPhaseCtl(highPhaseCtl),
    .strobes     (strobes)
  );

  twin_edge_path #(.DATA_W(DATA_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .dIn    (dIn),
    .strobes(strobes),
    .q      (q)
  );

endmodule

// File: rtl/twin_edge_reg_chk.sv
module twin_edge_reg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dIn,
  input logic [1:0]        lowPhaseCtl,
  input logic [1:0]        highPhaseCtl,
  input logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] seenAtRise;
  logic [DATA_W-1:0] seenAtFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenAtRise <= '0;
    else       seenAtRise <= dIn;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) seenAtFall <= '0;
    else       seenAtFall <= dIn;
  end

  // Sampled at a falling edge, the values are those of the high phase just ending.
  assert_rise_sample_R1: assert property (@(negedge clk) disable iff (!rstN)
    (highPhaseCtl == 2'b01) |-> (q == seenAtRise));

  // Sampled at a rising edge, the values are those of the low phase just ending.
  assert_fall_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lowPhaseCtl == 2'b01) |-> (q == seenAtFall));

  assert_low_forced_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lowPhaseCtl != 2'b01) |-> (q == {DATA_W{lowPhaseCtl[1]}}));

  assert_high_forced_R5: assert property (@(negedge clk) disable iff (!rstN)
    (highPhaseCtl != 2'b01) |-> (q == {DATA_W{highPhaseCtl[1]}}));

endmodule

bind twin_edge_reg twin_edge_reg_chk #(.DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .dIn         (dIn),
  .lowPhaseCtl (lowPhaseCtl),
  .highPhaseCtl(highPhaseCtl),
  .q           (q)
);

// File: tb/twin_edge_reg_test.sv
`timescale 1ns/1ps
module twin_edge_reg_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dIn = '0;
  logic [1:0]   lowPhaseCtl = 2'b01;
  logic [1:0]   highPhaseCtl = 2'b01;
  logic [W-1:0] q;

  int checks = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [W-1:0] refRise = '0;
  logic [W-1:0] refFall = '0;
  bit lowWasForced = 0;
  bit highWasForced = 0;

  always #5 clk = ~clk;

  twin_edge_reg #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .dIn(dIn),
    .lowPhaseCtl(lowPhaseCtl), .highPhaseCtl(highPhaseCtl), .q(q)
  );

  // Edge samples kept by the bench; inputs never change on an edge.
  always @(posedge clk or negedge rstN)
    if (!rstN) refRise = '0; else refRise = dIn;
  always @(negedge clk or negedge rstN)
    if (!rstN) refFall = '0; else refFall = dIn;

  function automatic logic [W-1:0] shown(input logic [1:0] ctl, input logic [W-1:0] held);
    if (ctl == 2'b01) return held;
    if (ctl == 2'b00) return '0;
    return '1;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] expected);
    checks++;
    if (q !== expected) begin
      fails++;
      $display("FAIL %s at %0t: q=%h expected=%h clk=%b low=%b high=%b",
               tag, $time, q, expected, clk, lowPhaseCtl, highPhaseCtl);
    end
  endtask

  task automatic checkNow();
    string tag;
    logic [W-1:0] expected;
    if (clk) begin
      expected = shown(highPhaseCtl, refRise);
      if (highPhaseCtl != 2'b01) tag = "R5";
      else if (highWasForced) tag = "R7";
      else tag = "R1/R3/R9";
      if (lowPhaseCtl != 2'b01) tag = {tag, " R6"};
    end else begin
      expected = shown(lowPhaseCtl, refFall);
      if (lowPhaseCtl != 2'b01) tag = "R4";
      else if (lowWasForced) tag = "R7";
      else tag = "R2/R3/R9";
      if (highPhaseCtl != 2'b01) tag = {tag, " R6"};
    end
    check(tag, expected);
  endtask

  // One half period: wait for an edge, move data (and maybe controls) mid-phase, then check.
  task automatic halfStep(input bit setCtl, input logic [1:0] newLow, input logic [1:0] newHigh);
    @(clk);
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dIn = lfsr[W-1:0] ^ lfsr[15:16-W];
    if (setCtl) begin
      lowWasForced  = (lowPhaseCtl != 2'b01);
      highWasForced = (highPhaseCtl != 2'b01);
      lowPhaseCtl  = newLow;
      highPhaseCtl = newHigh;
    end else begin
      lowWasForced = 0;
      highWasForced = 0;
    end
    #2;
    checkNow();
  endtask

  initial begin
    #3 check("R8 reset low phase", '0);
    #5 check("R8 reset high phase", '0);
    #4 rstN = 1'b1;

    // normal mode, random data on both edges
    for (int i = 0; i < 40; i++) halfStep(0, 2'b01, 2'b01);

    // sweep every pair of control codes
    for (int c = 0; c < 16; c++) begin
      halfStep(1, c[3:2], c[1:0]);
      for (int k = 0; k < 3; k++) halfStep(0, 2'b01, 2'b01);
      halfStep(1, 2'b01, 2'b01);
      halfStep(0, 2'b01, 2'b01);
    end

    // long forced stretch, then release mid-phase
    halfStep(1, 2'b00, 2'b00);
    for (int k = 0; k < 5; k++) halfStep(0, 2'b00, 2'b00);
    halfStep(1, 2'b01, 2'b01);
    halfStep(0, 2'b01, 2'b01);

    // asynchronous reset in the middle of a run
    @(clk);
    #2 rstN = 1'b0;
    #1 check("R8 async clear", '0);
    @(clk);
    #3 check("R8 held in reset", '0);
    rstN = 1'b1;
    for (int i = 0; i < 10; i++) halfStep(0, 2'b01, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule